// File: doc/BRIEF.md
# Stream Gap Insertion Trigger

This block watches the valid strobe of an incoming transport stream and measures the idle time since the last data beat. The gap timer counts in a split format: a low offset field that steps once per clock and wraps at a parameterized modulus, and a high count field that takes the carries. The 16-bit value {count, offset} is compared with a programmable threshold of the same layout.

Software arms the trigger by setting an enable level. Once armed, the block asks for a packet to be inserted when the measured gap is equal to or larger than the threshold. It then holds the request until the transmit side signals completion. It then pulses a clear strobe for one cycle, so that the enable register drops. One arming allows one insertion only: a further insertion needs the enable to fall and rise again.

The control states are ST_IDLE (not armed), ST_ARMED (waiting for a long enough gap), ST_INSERT (request held), ST_CLEAR (one-cycle clear pulse) and ST_SPENT (insertion done, waiting for the enable to drop). The transitions are: IDLE to ARMED when the enable is high; ARMED to IDLE when the enable is low; ARMED to INSERT when the enable is high and the gap reaches the threshold; INSERT to CLEAR on the completion strobe; CLEAR to SPENT always; SPENT to IDLE when the enable is low.

Top module: `gap_insert_trigger`

## Requirements
- R1: After reset the request and clear outputs are low, the gap timer reads zero and the controller is in ST_IDLE.
- R2: The gap timer returns to zero on every clock edge at which data_valid is high. After the last valid beat it advances by one offset step per clock.
- R3: The offset field (bits 11:0) wraps from OFS_MOD-1 to 0 and carries into the count field (bits 15:12). Once the count is 15 and the offset is OFS_MOD-1, the timer holds that value.
- R4: With the enable high, ins_req rises one clock after the registered gap value first becomes equal to or greater than thr, compared as an unsigned 16-bit number. A gap below the threshold raises no request.
- R5: While arm_en is low, no request is raised, whatever the gap.
- R6: Once raised, ins_req stays high until done_stb is seen. Neither new data_valid beats nor a falling arm_en cancel it.
- R7: At the edge that samples done_stb high in ST_INSERT, ins_req falls and clr_en goes high for exactly one clock.
- R8: After an insertion no further request is raised until arm_en has been seen low and then high again.
- R9: done_stb outside ST_INSERT has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_valid | input | 1 | Stream data present this cycle |
| arm_en | input | 1 | Insertion enable level from the control register |
| done_stb | input | 1 | Insertion completed strobe |
| thr | input | CNT_W+OFS_W | Gap threshold as {count, offset} |
| ins_req | output | 1 | Insertion request, held until completion |
| clr_en | output | 1 | One-cycle pulse telling the register to clear the enable |

## Verification
The bench builds the block with OFS_MOD set to 16 instead of the full-size modulus. With that setting the offset wrap and the carry into the count field are reached within a few dozen idle cycles. Full saturation at count 15 is reached within 256 cycles. This brings thresholds in the count field, the maximum reachable threshold, and an unreachable one (offset bits at or above the modulus) within a short run.

// File: rtl/gap_pkg.sv
package gap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_INSERT = 3'd2,
        ST_CLEAR  = 3'd3,
        ST_SPENT  = 3'd4
    } trig_state_t;
endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int CNT_W   = 4,
    parameter int OFS_W   = 12,
    parameter int OFS_MOD = 3072,
    localparam int GAP_W  = CNT_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_valid,
    output logic [GAP_W-1:0] gap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [OFS_W-1:0] OFS_TOP = OFS_W'(OFS_MOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [OFS_W-1:0] ofs_q;
    logic             ofs_wrap;
    logic             full;

    assign ofs_wrap = (ofs_q == OFS_TOP);
    assign full     = ofs_wrap && (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ofs_q <= '0;
        end else if (data_valid) begin
            cnt_q <= '0;
            ofs_q <= '0;
        end else if (full) begin
            cnt_q <= cnt_q;
            ofs_q <= ofs_q;
        end else if (ofs_wrap) begin
            cnt_q <= cnt_q + 1'b1;
            ofs_q <= '0;
        end else begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    assign gap = {cnt_q, ofs_q};
endmodule

// File: rtl/gap_cmp.sv
module gap_cmp #(
    parameter int GAP_W = 16
) (
    input  logic [GAP_W-1:0] gap,
    input  logic [GAP_W-1:0] thr,
    output logic             gap_ok
);
    // Count field is the upper bits, so a plain unsigned compare orders correctly.
    assign gap_ok = (gap >= thr);
endmodule

// File: rtl/insert_fsm.sv
module insert_fsm
    import gap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_en,
    input  logic        gap_ok,
    input  logic        done_stb,
    output logic        ins_req,
    output logic        clr_en,
    output trig_state_t state
);
    trig_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (arm_en) st_d = ST_ARMED;
            ST_ARMED: begin
                if (!arm_en)     st_d = ST_IDLE;
                else if (gap_ok) st_d = ST_INSERT;
            end
            ST_INSERT: if (done_stb) st_d = ST_CLEAR;
            ST_CLEAR:  st_d = ST_SPENT;
            ST_SPENT:  if (!arm_en) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        ins_req = 1'b0;
        clr_en  = 1'b0;
        unique case (st_q)
            ST_INSERT: ins_req = 1'b1;
            ST_CLEAR:  clr_en  = 1'b1;
            default: begin
                ins_req = 1'b0;
                clr_en  = 1'b0;
            end
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/gap_insert_trigger.sv
module gap_insert_trigger #(
    parameter int CNT_W   = 4,
    parameter int OFS_W   = 12,
    parameter int OFS_MOD = 3072,
    localparam int GAP_W  = CNT_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_valid,
    input  logic             arm_en,
    input  logic             done_stb,
    input  logic [GAP_W-1:0] thr,
    output logic             ins_req,
    output logic             clr_en
);
    import gap_pkg::*;

    logic [GAP_W-1:0] gap_val;
    logic             gap_ok;
    trig_state_t      fsm_state;

    gap_timer #(
        .CNT_W   (CNT_W),
        .OFS_W   (OFS_W),
        .OFS_MOD (OFS_MOD)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_valid (data_valid),
        .gap        (gap_val)
    );

    gap_cmp #(
        .GAP_W (GAP_W)
    ) cmp_i (
        .gap    (gap_val),
        .thr    (thr),
        .gap_ok (gap_ok)
    );

    insert_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_en   (arm_en),
        .gap_ok   (gap_ok),
        .done_stb (done_stb),
        .ins_req  (ins_req),
        .clr_en   (clr_en),
        .state    (fsm_state)
    );
endmodule

// File: rtl/gap_insert_trigger_chk.sv
module gap_insert_trigger_chk #(
    parameter int CNT_W   = 4,
    parameter int OFS_W   = 12,
    parameter int OFS_MOD = 3072,
    localparam int GAP_W  = CNT_W + OFS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_valid,
    input logic             arm_en,
    input logic             done_stb,
    input logic [GAP_W-1:0] thr,
    input logic             ins_req,
    input logic             clr_en,
    input logic [GAP_W-1:0] gap_val
);
    localparam logic [GAP_W-1:0] GAP_FULL = {{CNT_W{1'b1}}, OFS_W'(OFS_MOD - 1)};

    p_gap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> (gap_val == '0));

    p_gap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_val == GAP_FULL) && !data_valid |=> (gap_val == GAP_FULL));

    p_ofs_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gap_val[OFS_W-1:0] < OFS_W'(OFS_MOD));

    p_rise_on_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> $past(gap_val >= thr));

    p_rise_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> $past(arm_en));

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req && !done_stb |=> ins_req);

    p_req_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req && done_stb |=> !ins_req && clr_en);

    p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !clr_en && !ins_req);

    p_out_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_req && clr_en));
endmodule

bind gap_insert_trigger gap_insert_trigger_chk #(
    .CNT_W   (CNT_W),
    .OFS_W   (OFS_W),
    .OFS_MOD (OFS_MOD)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_valid (data_valid),
    .arm_en     (arm_en),
    .done_stb   (done_stb),
    .thr        (thr),
    .ins_req    (ins_req),
    .clr_en     (clr_en),
    .gap_val    (gap_val)
);

// File: tb/gap_insert_trigger_tb_top.sv
`timescale 1ns/1ps
module gap_insert_trigger_tb_top;
    localparam int CNT_W   = 4;
    localparam int OFS_W   = 12;
    localparam int OFS_MOD = 16;
    localparam int GAP_W   = CNT_W + OFS_W;

    localparam int M_IDLE = 0, M_ARMED = 1, M_INSERT = 2, M_CLEAR = 3, M_SPENT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_valid = 1'b0;
    logic             arm_en = 1'b0;
    logic             done_stb = 1'b0;
    logic [GAP_W-1:0] thr = '0;
    logic             ins_req;
    logic             clr_en;

    int    n_checks = 0;
    int    n_errors = 0;
    int    m_st = M_IDLE;
    int    m_idle = 0;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    gap_insert_trigger #(
        .CNT_W   (CNT_W),
        .OFS_W   (OFS_W),
        .OFS_MOD (OFS_MOD)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_valid (data_valid),
        .arm_en     (arm_en),
        .done_stb   (done_stb),
        .thr        (thr),
        .ins_req    (ins_req),
        .clr_en     (clr_en)
    );

    // Expected gap value after n idle edges (R2, R3).
    function automatic logic [GAP_W-1:0] gap_of(input int n);
        int c;
        c = n / OFS_MOD;
        if (c > 15) return {4'hF, 12'(OFS_MOD - 1)};
        return {4'(c), 12'(n % OFS_MOD)};
    endfunction

    function automatic int next_state(input int st, input bit arm, input bit ok, input bit done);
        case (st)
            M_IDLE:   return arm ? M_ARMED : M_IDLE;
            M_ARMED:  return !arm ? M_IDLE : (ok ? M_INSERT : M_ARMED);
            M_INSERT: return done ? M_CLEAR : M_INSERT;
            M_CLEAR:  return M_SPENT;
            default:  return arm ? M_SPENT : M_IDLE;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit dv, input bit arm, input bit done);
        bit ok;
        data_valid = dv;
        arm_en     = arm;
        done_stb   = done;
        @(posedge clk);
        ok     = (gap_of(m_idle) >= thr);
        m_st   = next_state(m_st, arm, ok, done);
        m_idle = dv ? 0 : ((m_idle < 100000) ? m_idle + 1 : m_idle);
        @(negedge clk);
        check(cur_tag, ins_req, m_st == M_INSERT, "ins_req");
        check(cur_tag, clr_en,  m_st == M_CLEAR,  "clr_en");
    endtask

    task automatic idle(input int n, input bit arm);
        for (int i = 0; i < n; i++) step(1'b0, arm, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        check("R1", ins_req, 1'b0, "ins_req after reset");
        check("R1", clr_en,  1'b0, "clr_en after reset");

        // R5: long gap, tiny threshold, never armed
        cur_tag = "R5";
        thr = 16'h0003;
        idle(40, 1'b0);

        // R4: exact boundary at threshold 5
        cur_tag = "R4";
        step(1'b1, 1'b1, 1'b0);
        thr = 16'h0005;
        idle(4, 1'b1);
        check("R4", ins_req, 1'b0, "below threshold");
        idle(3, 1'b1);

        // R6: data and disarm during a held request
        cur_tag = "R6";
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        idle(3, 1'b0);
        check("R6", ins_req, 1'b1, "request held");

        // R7: completion pulse
        cur_tag = "R7";
        step(1'b0, 1'b1, 1'b1);
        idle(2, 1'b1);

        // R8: stays spent while enable remains high, re-arm needs a low
        cur_tag = "R8";
        idle(30, 1'b1);
        check("R8", ins_req, 1'b0, "no second insertion");
        step(1'b0, 1'b0, 1'b0);
        idle(3, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        idle(2, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // R9: stray completion strobes while armed and idle
        cur_tag = "R9";
        thr = 16'hF010;
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, i[0]);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);

        // R2: data beats shorter than threshold keep restarting the gap
        cur_tag = "R2";
        thr = 16'h0008;
        for (int i = 0; i < 48; i++) step((i % 6) == 0, 1'b1, 1'b0);
        check("R2", ins_req, 1'b0, "gap restarted by data");
        idle(6, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // R3: threshold in count field, full saturation and unreachable value
        cur_tag = "R3";
        thr = {4'd2, 12'd3};
        step(1'b1, 1'b1, 1'b0);
        idle(40, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        thr = {4'hF, 12'(OFS_MOD - 1)};
        step(1'b1, 1'b1, 1'b0);
        idle(262, 1'b1);
        check("R3", ins_req, 1'b1, "saturated gap meets max threshold");
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        thr = {4'hF, 12'(OFS_MOD)};
        step(1'b1, 1'b1, 1'b0);
        idle(300, 1'b1);
        check("R3", ins_req, 1'b0, "unreachable threshold");
        step(1'b0, 1'b0, 1'b0);

        // Random traffic against the reference model
        cur_tag = "R4";
        void'($urandom(32'h5EED_1394));
        for (int i = 0; i < 4000; i++) begin
            bit dv, arm, done;
            if ((i % 200) == 0) thr = {4'($urandom_range(0, 2)), 12'($urandom_range(0, OFS_MOD))};
            dv   = ($urandom_range(0, 99) < 8);
            arm  = ($urandom_range(0, 99) < 90);
            done = ($urandom_range(0, 99) < 10);
            step(dv, arm, done);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule